// File: doc/BRIEF.md
# SPI Slave Transmit Padding Inserter

This block is the transmit half of an SPI slave. It sits between a byte-wide, show-ahead transmit FIFO and the MISO pin, and it serialises bytes MSB first in SPI mode 0 (master samples on rising SCK, slave updates on falling SCK). SCK and the active-low select are brought into the system clock domain through synchronizer chains. All decisions are made in that domain, so the system clock must run well above SCK.

Software or a DMA engine keeps the FIFO fed. Once a select window has seen at least one received-byte-valid pulse, the block becomes armed. While armed, any time the FIFO has been empty and then gets a byte, the serializer first sends one padding byte and only then the new byte. The padding byte is a full byte of the stream, just as if it had been written into the FIFO. This gives the FIFO a whole byte time to present the next real byte. A configuration input picks the padding value: all ones, or a repeat of the byte transmitted last. If a byte has to start while the FIFO is empty, the same padding value goes out and an underrun flag pulses.

Top module: `spitx_pad_inserter`

## Requirements
- R1: When select asserts, the byte at the FIFO head is popped and its MSB is on MISO before the first rising SCK edge. The following bits go out MSB first, and each later byte is loaded on the falling SCK edge that follows the eighth rising edge of the previous byte.
- R2: MISO changes only in response to a falling SCK edge, a byte load, or deselection. It is stable for the whole high phase of SCK.
- R3: The block becomes armed only after a received-byte-valid pulse inside the current select window. Before that, a byte written into an empty FIFO is sent with no padding byte ahead of it.
- R4: While armed, if the FIFO has been empty at any point since the last byte load and now holds data, the next byte sent is one padding byte, followed by the FIFO byte. The padding byte does not pop the FIFO.
- R5: With `pad_sel_i` = 0 the padding value is 0xFF.
- R6: With `pad_sel_i` = 1 the padding value is the byte loaded most recently, padding bytes included. After reset that value is 0xFF.
- R7: Deasserting select disarms the block. In the next window, bytes are sent without padding until a new received-byte-valid pulse arrives.
- R8: A byte load while the FIFO is empty sends the current padding value and raises `underrun_o` for exactly one clock.
- R9: `tx_idle_o` is high exactly when the FIFO is empty and no byte is in progress. A byte is in progress from its load until its eighth rising SCK edge, and never while deselected.
- R10: `fifo_pop_o` is a single-cycle pulse, raised only when the FIFO is not empty, once per FIFO byte sent.
- R11: Deasserting select in the middle of a byte abandons that byte. The next window starts with a fresh byte, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock from the master (asynchronous) |
| ssel_n_i | input | 1 | Active-low slave select (asynchronous) |
| rx_valid_i | input | 1 | One-cycle pulse when the receive side has accepted a byte |
| pad_sel_i | input | 1 | Padding value select: 0 gives all ones, 1 repeats the last byte |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | DW | Transmit FIFO head byte (show-ahead) |
| fifo_pop_o | output | 1 | Pop strobe to the transmit FIFO |
| miso_o | output | 1 | Serial data to the master |
| tx_idle_o | output | 1 | FIFO empty and no byte in progress |
| underrun_o | output | 1 | One-cycle pulse when a byte starts with the FIFO empty |

## Verification
The bench builds the block with its defaults: an 8-bit data width and a two-stage synchronizer. It drives SCK with a half period of eight system clocks, so the clock ratio is 16. This leaves the full synchronizer latency well inside each SCK phase, and it makes both the start-of-window load and the falling-edge loads reachable with enough margin for the master-side sampling model. Both padding selections are exercised across underruns, armed refills, reselection and a window abandoned mid-byte. The full 8-bit width means the repeat-last padding value can be told apart from the all-ones value.

// File: rtl/spitx_pkg.sv
package spitx_pkg;

  // Where the next serialised byte comes from.
  typedef enum logic [1:0] {
    SRC_FIFO = 2'd0,
    SRC_PAD  = 2'd1,
    SRC_FILL = 2'd2
  } src_e;

  // An empty FIFO forces a fill byte. An owed pad goes ahead of fresh data.
  function automatic src_e pick_src(input logic fifo_empty, input logic owed);
    if (fifo_empty)  return SRC_FILL;
    else if (owed)   return SRC_PAD;
    else             return SRC_FIFO;
  endfunction

endpackage

// File: rtl/spitx_sync.sv
module spitx_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spitx_frame.sv
module spitx_frame #(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s_i,
  input  logic ssel_n_s_i,
  output logic sel_o,
  output logic sck_fall_o,
  output logic load_evt_o,
  output logic shift_evt_o,
  output logic busy_o
);

  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          sck_q;
  logic          sel_q;
  logic          need_load;
  logic [CW-1:0] bit_cnt;
  logic          sck_rise;
  logic          sel_start;
  logic          byte_end;

  assign sel_o       = ~ssel_n_s_i;
  assign sck_rise    = sel_o & sck_s_i & ~sck_q;
  assign sck_fall_o  = sel_o & ~sck_s_i & sck_q;
  assign sel_start   = sel_o & ~sel_q;
  assign byte_end    = sck_rise & (bit_cnt == LAST_BIT);
  assign load_evt_o  = sel_start | (sck_fall_o & need_load);
  assign shift_evt_o = sck_fall_o & ~need_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      sel_q <= sel_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      need_load <= 1'b0;
      busy_o    <= 1'b0;
    end else if (!sel_o) begin
      bit_cnt   <= '0;
      need_load <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      if (sck_rise) bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
      if (byte_end)        need_load <= 1'b1;
      else if (load_evt_o) need_load <= 1'b0;
      if (load_evt_o)      busy_o <= 1'b1;
      else if (byte_end)   busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/spitx_arm.sv
module spitx_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic rx_valid_i,
  input  logic fifo_empty_i,
  input  logic pad_load_i,
  output logic armed_o,
  output logic owed_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      owed_o  <= 1'b0;
    end else if (!sel_i) begin
      armed_o <= 1'b0;
      owed_o  <= 1'b0;
    end else begin
      armed_o <= armed_o | rx_valid_i;
      owed_o  <= armed_o & ~pad_load_i & (owed_o | fifo_empty_i);
    end
  end

endmodule

// File: rtl/spitx_shift.sv
module spitx_shift
  import spitx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          load_evt_i,
  input  logic          shift_evt_i,
  input  logic          owed_i,
  input  logic          pad_cfg_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          pop_o,
  output logic          pad_load_o,
  output logic          underrun_o,
  output logic          miso_o
);

  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  function automatic logic [DW-1:0] pad_value(input logic cfg, input logic [DW-1:0] last);
    return cfg ? last : ONES;
  endfunction

  src_e          src;
  logic [DW-1:0] sh;
  logic [DW-1:0] last_q;
  logic [DW-1:0] load_val;

  assign src        = pick_src(fifo_empty_i, owed_i);
  assign load_val   = (src == SRC_FIFO) ? fifo_data_i : pad_value(pad_cfg_i, last_q);
  assign pop_o      = load_evt_i & (src == SRC_FIFO);
  assign pad_load_o = load_evt_i & (src == SRC_PAD);
  assign miso_o     = sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= ONES;
      last_q     <= ONES;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= load_evt_i & (src == SRC_FILL);
      if (load_evt_i) last_q <= load_val;
      if (!sel_i)           sh <= ONES;
      else if (load_evt_i)  sh <= load_val;
      else if (shift_evt_i) sh <= {sh[DW-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/spitx_pad_inserter.sv
module spitx_pad_inserter #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          ssel_n_i,
  input  logic          rx_valid_i,
  input  logic          pad_sel_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          fifo_pop_o,
  output logic          miso_o,
  output logic          tx_idle_o,
  output logic          underrun_o
);

  logic sck_s;
  logic ssel_n_s;
  logic sel;
  logic sck_fall;
  logic load_evt;
  logic shift_evt;
  logic busy;
  logic armed;
  logic owed;
  logic pad_load;

  spitx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ssel_n_i, sck_i}),
    .q_o   ({ssel_n_s, sck_s})
  );

  spitx_frame #(.DW(DW)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_s_i     (sck_s),
    .ssel_n_s_i  (ssel_n_s),
    .sel_o       (sel),
    .sck_fall_o  (sck_fall),
    .load_evt_o  (load_evt),
    .shift_evt_o (shift_evt),
    .busy_o      (busy)
  );

  spitx_arm u_arm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel),
    .rx_valid_i   (rx_valid_i),
    .fifo_empty_i (fifo_empty_i),
    .pad_load_i   (pad_load),
    .armed_o      (armed),
    .owed_o       (owed)
  );

  spitx_shift #(.DW(DW)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel),
    .load_evt_i   (load_evt),
    .shift_evt_i  (shift_evt),
    .owed_i       (owed),
    .pad_cfg_i    (pad_sel_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .pop_o        (fifo_pop_o),
    .pad_load_o   (pad_load),
    .underrun_o   (underrun_o),
    .miso_o       (miso_o)
  );

  assign tx_idle_o = fifo_empty_i & ~busy;

endmodule

// File: rtl/spitx_pad_chk.sv
module spitx_pad_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty_i,
  input logic fifo_pop_o,
  input logic rx_valid_i,
  input logic miso_o,
  input logic underrun_o,
  input logic sel,
  input logic sck_fall,
  input logic load_evt,
  input logic pad_load,
  input logic armed
);

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  // R10
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |=> !fifo_pop_o);

  // R8
  underrun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> $past(fifo_empty_i) && $past(load_evt));

  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);

  // R4
  pad_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_load |-> armed && !fifo_empty_i && !fifo_pop_o);

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !armed);

  // R3
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(rx_valid_i) && $past(sel));

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel && $past(sel) && !$past(load_evt) && !$past(sck_fall) |-> $stable(miso_o));

endmodule

bind spitx_pad_inserter spitx_pad_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_empty_i (fifo_empty_i),
  .fifo_pop_o   (fifo_pop_o),
  .rx_valid_i   (rx_valid_i),
  .miso_o       (miso_o),
  .underrun_o   (underrun_o),
  .sel          (sel),
  .sck_fall     (sck_fall),
  .load_evt     (load_evt),
  .pad_load     (pad_load),
  .armed        (armed)
);

// File: tb/sim_spitx_pad_inserter.sv
module sim_spitx_pad_inserter;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       ssel_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic       pad_sel = 1'b0;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_pop;
  logic       miso;
  logic       tx_idle;
  logic       underrun;

  spitx_pad_inserter u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_i        (sck),
    .ssel_n_i     (ssel_n),
    .rx_valid_i   (rx_valid),
    .pad_sel_i    (pad_sel),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .fifo_pop_o   (fifo_pop),
    .miso_o       (miso),
    .tx_idle_o    (tx_idle),
    .underrun_o   (underrun)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] fq[$];
  logic [7:0] mq[$];
  logic [7:0] exp_q[$];
  bit   armed_m = 0;
  bit   owed_m  = 0;
  logic [7:0] last_m = 8'hFF;
  int   exp_ur = 0;
  int   ur_cnt = 0;
  int   exp_pops = 0;
  int   pop_cnt = 0;
  bit   pop_seen = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? 8'h00 : fq[0];
  endtask

  // Bench FIFO plus per-clock observation of pops and underrun pulses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_seen && fq.size() > 0) void'(fq.pop_front());
      if (fifo_pop) begin
        pop_cnt++;
        if (fq.size() == 0) chk(0, "R10 pop with empty FIFO", 1, 0);
      end
      pop_seen = fifo_pop;
      if (underrun) ur_cnt++;
      refresh();
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fq.push_back(b);
    mq.push_back(b);
    refresh();
    repeat (2) @(negedge clk);
  endtask

  // Reference: decides what the next loaded byte must be.
  task automatic predict();
    logic [7:0] v;
    logic [7:0] padv;
    padv = pad_sel ? last_m : 8'hFF;
    if (mq.size() == 0) begin
      v = padv;
      exp_ur++;
      if (armed_m) owed_m = 1;
    end else if (armed_m && owed_m) begin
      v = padv;
      owed_m = 0;
    end else begin
      v = mq.pop_front();
      exp_pops++;
      if (armed_m && mq.size() == 0) owed_m = 1;
    end
    last_m = v;
    exp_q.push_back(v);
  endtask

  task automatic sel_on();
    @(negedge clk);
    ssel_n = 1'b0;
    repeat (6) @(negedge clk);
    predict();
  endtask

  task automatic sel_off();
    @(negedge clk);
    ssel_n = 1'b1;
    repeat (6) @(negedge clk);
    armed_m = 0;
    owed_m  = 0;
    exp_q.delete();
  endtask

  task automatic rx_pulse();
    @(negedge clk);
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    armed_m = 1;
    if (mq.size() == 0) owed_m = 1;
  endtask

  task automatic xfer(input string tag, input int nbits = 8);
    logic [7:0] got;
    logic [7:0] e;
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      got[7-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(miso == got[7-i], "R2 MISO moved while SCK high", miso, got[7-i]);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i == 3) chk(tx_idle == 1'b0, "R9 idle low mid-byte", tx_idle, 0);
    end
    if (nbits == 8) begin
      repeat (4) @(negedge clk);
      e = exp_q.pop_front();
      chk(got == e, tag, got, e);
      predict();
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state
    chk(tx_idle == 1'b1, "R9 idle after reset", tx_idle, 1);
    chk(fifo_pop == 1'b0, "R10 no pop after reset", fifo_pop, 0);
    chk(underrun == 1'b0, "R8 no underrun after reset", underrun, 0);
    chk(miso == 1'b1, "R2 MISO high while deselected", miso, 1);

    // Window 1, all-ones padding
    pad_sel = 1'b0;
    push(8'hA5);
    push(8'h3C);
    chk(tx_idle == 1'b0, "R9 idle low with data queued", tx_idle, 0);
    sel_on();
    xfer("R1 first byte from FIFO head");
    xfer("R1 second byte MSB first");
    chk(ur_cnt == exp_ur, "R8 underrun pulse count", ur_cnt, exp_ur);
    xfer("R8 fill byte uses 0xFF");
    push(8'h81);
    xfer("R8 second fill byte");
    xfer("R3 no pad before arming");
    rx_pulse();
    push(8'h42);
    push(8'h99);
    xfer("R8 fill already loaded");
    xfer("R4 R5 pad byte 0xFF after refill");
    xfer("R4 first data after pad");
    xfer("R4 second data no extra pad");
    push(8'h17);
    xfer("R8 fill while armed");
    xfer("R4 pad again after re-empty");
    xfer("R4 data after second pad");
    sel_off();
    chk(tx_idle == 1'b1, "R9 idle when deselected and empty", tx_idle, 1);
    chk(ur_cnt == exp_ur, "R8 underrun total window 1", ur_cnt, exp_ur);

    // Window 2, repeat-last padding
    pad_sel = 1'b1;
    push(8'h6E);
    sel_on();
    xfer("R7 no pad after reselect");
    xfer("R6 fill repeats last byte");
    rx_pulse();
    push(8'hD2);
    xfer("R6 fill repeats again");
    xfer("R6 pad repeats last byte");
    xfer("R4 data after repeat pad");
    sel_off();

    // Window 3 abandoned mid-byte, window 4 fresh
    push(8'hC3);
    push(8'h5A);
    sel_on();
    xfer("R11 partial", 3);
    sel_off();
    chk(miso == 1'b1, "R11 MISO released on deselect", miso, 1);
    sel_on();
    xfer("R11 fresh byte after abort");
    sel_off();

    chk(pop_cnt == exp_pops, "R10 pop count", pop_cnt, exp_pops);
    chk(ur_cnt == exp_ur, "R8 underrun total", ur_cnt, exp_ur);
    done = 1;
    report();
  end

endmodule